// File: doc/BRIEF.md
# Asynchronous static RAM strobe controller

This block sits between a clocked host and an external asynchronous static RAM of 16K words by 4 bits that shares one bidirectional data bus for reads and writes. The host hands over one word-sized request at a time through a valid/ready handshake: an address, a direction flag, a write word and a flag that asks for output enable to stay asserted through a write. The controller then plays out the chip select, write enable and output enable strobes on a fixed cycle schedule and moves the data. It returns read data together with a one-cycle done pulse.

Each phase of the schedule is a whole number of clock cycles. The phases are address setup with chip select high, read access, write strobe and write recovery. Their lengths come from nanosecond parameters, each rounded up to whole clock periods. Between transactions chip select is high, so an idle memory sits in standby with its data pins floating. The data bus is split into an output word, a drive enable and an input word. The chip-level pad joins them.

When a write keeps output enable asserted, the memory needs time to turn off its own drivers before the controller may drive the bus. The strobe is then widened to the sum of that turn-off time and the data setup time, if that sum is longer than the plain minimum pulse. The controller holds its drivers off for the turn-off portion of the strobe.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, ram_cs_n, ram_we_n and ram_oe_n are 1, ram_dq_oe and rsp_done are 0, and req_ready is 1.
- R2: A request is taken only in a cycle where req_ready is 1. Changes to req_addr, req_wdata, req_write, req_keep_oe or req_valid while a transaction runs do not alter the memory-side address, the driven data or the schedule.
- R3: After a request is taken, the captured address is presented for SETUP cycles with ram_cs_n at 1 before any strobe falls (SETUP = address setup rounded up, at least 1). ram_addr does not change in any cycle in which ram_cs_n is 0.
- R4: A read holds ram_cs_n = 0, ram_oe_n = 0 and ram_we_n = 1 for ACC cycles (ACC = access time rounded up, at least 1). The word on ram_dq_in is captured at the clock edge that ends the last of those cycles.
- R5: After each transaction comes exactly one cycle with rsp_done = 1 and all strobes at 1. For a read, rsp_rdata in that cycle equals the word last written to that address. req_ready returns to 1 in the next cycle.
- R6: A write with req_keep_oe = 0 holds ram_cs_n = 0 and ram_we_n = 0 with ram_oe_n = 1 for WP cycles (WP = minimum write pulse rounded up). The write word is driven, with ram_dq_oe = 1, for the whole strobe.
- R7: A write with req_keep_oe = 1 keeps ram_oe_n = 0 through the strobe. The strobe lasts max(WP, OFF + DS) cycles, where OFF is the bus turn-off time rounded up and DS is the data setup time rounded up. ram_dq_oe stays 0 for the first OFF strobe cycles and is 1 for the rest.
- R8: ram_dq_oe is 1 only during a write strobe or in the single cycle after it. It is never 1 while the memory is reading (ram_cs_n = 0, ram_we_n = 1, ram_oe_n = 0).
- R9: After the write strobe, ram_cs_n and ram_we_n stay 1 for REC cycles before the done cycle. REC = max(1, recovery time rounded up, write cycle rounded up − SETUP − WP).
- R10: The cycle counts follow from the nanosecond parameters and the clock period. With a 10 ns clock, 0/45/35/20/25/40/0 ns for address setup, access, pulse, data setup, turn-off, write cycle and recovery give SETUP 1, ACC 5, WP 4, widened pulse 5, OFF 3, REC 1.
- R11: Whenever req_ready is 1, ram_cs_n, ram_we_n and ram_oe_n are all 1 and ram_dq_oe is 0, so the memory is in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_keep_oe | input | 1 | 1 = keep output enable asserted through a write |
| req_addr | input | 14 | Word address |
| req_wdata | input | 4 | Write word |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 4 | Read word, valid with rsp_done after a read |
| ram_cs_n | output | 1 | Memory chip select, active low |
| ram_we_n | output | 1 | Memory write enable, active low |
| ram_oe_n | output | 1 | Memory output enable, active low |
| ram_addr | output | 14 | Memory address |
| ram_dq_out | output | 4 | Word to drive onto the data bus |
| ram_dq_oe | output | 1 | Data bus drive enable |
| ram_dq_in | input | 4 | Word sampled from the data bus |

## Verification
A request seen with req_ready high is taken at that edge. The setup cycle follows one cycle later. The strobe phases follow back to back, so rsp_done for a read is due 1 + SETUP + ACC cycles after the accepting edge, and for a write 1 + SETUP + strobe + REC cycles after it. When a request is issued, the bench queues one expected frame per cycle for the whole schedule, including the strobes, drive enable, address, driven word and read word. It pops and compares one frame at every falling clock edge, so a phase that is one cycle long or short fails on the exact cycle where it differs. A behavioural memory on the bus commits a write when the strobe overlap ends, and it reports bus contention at the same falling-edge samples.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_READ  = 3'd2,
    ST_WSTRB = 3'd3,
    ST_WREC  = 3'd4,
    ST_DONE  = 3'd5
  } ctl_state_t;

  // whole clock periods covering a span in nanoseconds
  function automatic int cycles_ceil(input int span_ns, input int period_ns);
    if (span_ns <= 0) return 0;
    return (span_ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  // width needed to hold values 0..v
  function automatic int count_width(input int v);
    int w;
    w = 1;
    while ((1 << w) <= v) w++;
    return w;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] remain,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign remain = cnt_q;
  assign last   = (cnt_q == '0);

endmodule

// File: rtl/sram_req_capture.sv
module sram_req_capture #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              in_write,
  input  logic              in_keep_oe,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              cur_write,
  output logic              cur_keep_oe,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_write   <= 1'b0;
      cur_keep_oe <= 1'b0;
      cur_addr    <= '0;
      cur_wdata   <= '0;
    end else if (take) begin
      cur_write   <= in_write;
      cur_keep_oe <= in_keep_oe;
      cur_addr    <= in_addr;
      cur_wdata   <= in_wdata;
    end
  end

endmodule

// File: rtl/sram_rd_latch.sv
module sram_rd_latch #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grab,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (grab) begin
      word <= bus_in;
    end
  end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W          = 14,
  parameter int DATA_W          = 4,
  parameter int CLK_PERIOD_NS   = 10,
  parameter int T_ADDR_SETUP_NS = 0,
  parameter int T_ACCESS_NS     = 45,
  parameter int T_WPULSE_NS     = 35,
  parameter int T_DSETUP_NS     = 20,
  parameter int T_BUS_OFF_NS    = 15,
  parameter int T_WCYCLE_NS     = 40,
  parameter int T_WREC_NS       = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_keep_oe,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              ram_cs_n,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);

  // phase lengths in cycles
  localparam int SETUP_CYC   = at_least_one(cycles_ceil(T_ADDR_SETUP_NS, CLK_PERIOD_NS));
  localparam int ACC_CYC     = at_least_one(cycles_ceil(T_ACCESS_NS, CLK_PERIOD_NS));
  localparam int WP_PLAIN    = at_least_one(cycles_ceil(T_WPULSE_NS, CLK_PERIOD_NS));
  localparam int OFF_CYC     = cycles_ceil(T_BUS_OFF_NS, CLK_PERIOD_NS);
  localparam int DS_CYC      = at_least_one(cycles_ceil(T_DSETUP_NS, CLK_PERIOD_NS));
  localparam int WP_WIDE     = max_int(WP_PLAIN, OFF_CYC + DS_CYC);
  localparam int REC_CYC     = at_least_one(max_int(cycles_ceil(T_WREC_NS, CLK_PERIOD_NS),
                                   cycles_ceil(T_WCYCLE_NS, CLK_PERIOD_NS) - SETUP_CYC - WP_PLAIN));
  localparam int LONGEST     = max_int(max_int(SETUP_CYC, ACC_CYC), max_int(WP_WIDE, REC_CYC));
  localparam int CNT_W       = count_width(LONGEST);
  localparam int DRV_FROM    = WP_WIDE - OFF_CYC - 1;

  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] ACC_LD   = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] WPP_LD   = CNT_W'(WP_PLAIN - 1);
  localparam logic [CNT_W-1:0] WPW_LD   = CNT_W'(WP_WIDE - 1);
  localparam logic [CNT_W-1:0] REC_LD   = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] DRV_LIM  = CNT_W'(DRV_FROM);

  ctl_state_t state_q, state_d;

  // named internal events
  logic             accept_evt;
  logic             capture_evt;
  logic             strobe_end_evt;
  logic             rec_first;
  logic             phase_last;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic [CNT_W-1:0] t_remain;

  logic              cur_write, cur_keep_oe;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;

  assign req_ready      = (state_q == ST_IDLE);
  assign accept_evt     = req_ready && req_valid;
  assign capture_evt    = (state_q == ST_READ) && phase_last;
  assign strobe_end_evt = (state_q == ST_WSTRB) && phase_last;
  assign rec_first      = (state_q == ST_WREC) && (t_remain == REC_LD);

  sram_req_capture #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (accept_evt),
    .in_write    (req_write),
    .in_keep_oe  (req_keep_oe),
    .in_addr     (req_addr),
    .in_wdata    (req_wdata),
    .cur_write   (cur_write),
    .cur_keep_oe (cur_keep_oe),
    .cur_addr    (cur_addr),
    .cur_wdata   (cur_wdata)
  );

  sram_phase_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .remain   (t_remain),
    .last     (phase_last)
  );

  sram_rd_latch #(
    .DATA_W (DATA_W)
  ) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .grab   (capture_evt),
    .bus_in (ram_dq_in),
    .word   (rsp_rdata)
  );

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_evt) begin
          state_d = ST_SETUP;
          t_load  = 1'b1;
          t_val   = SETUP_LD;
        end
      end
      ST_SETUP: begin
        if (phase_last) begin
          t_load = 1'b1;
          if (cur_write) begin
            state_d = ST_WSTRB;
            t_val   = cur_keep_oe ? WPW_LD : WPP_LD;
          end else begin
            state_d = ST_READ;
            t_val   = ACC_LD;
          end
        end
      end
      ST_READ: begin
        if (phase_last) state_d = ST_DONE;
      end
      ST_WSTRB: begin
        if (phase_last) begin
          state_d = ST_WREC;
          t_load  = 1'b1;
          t_val   = REC_LD;
        end
      end
      ST_WREC: begin
        if (phase_last) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  logic in_strobe, in_read, strobe_drive;

  assign in_strobe    = (state_q == ST_WSTRB);
  assign in_read      = (state_q == ST_READ);
  assign strobe_drive = in_strobe && (!cur_keep_oe || (t_remain <= DRV_LIM));

  assign rsp_done   = (state_q == ST_DONE);
  assign ram_cs_n   = !(in_read || in_strobe);
  assign ram_we_n   = !in_strobe;
  assign ram_oe_n   = !(in_read || (in_strobe && cur_keep_oe));
  assign ram_addr   = cur_addr;
  assign ram_dq_out = cur_wdata;
  assign ram_dq_oe  = strobe_drive || rec_first;

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              ram_cs_n,
  input logic              ram_we_n,
  input logic              ram_oe_n,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_dq_oe,
  input logic              accept_evt,
  input logic              capture_evt,
  input logic              strobe_end_evt
);

  assert_setup_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (ram_cs_n && !req_ready));

  assert_addr_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cs_n |-> $stable(ram_addr));

  assert_capture_in_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |-> (!ram_cs_n && !ram_oe_n && ram_we_n));

  assert_capture_then_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> rsp_done);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && req_ready));

  assert_we_inside_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> !ram_cs_n);

  assert_no_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_cs_n && ram_we_n && !ram_oe_n) |-> !ram_dq_oe);

  assert_drive_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> (!ram_we_n || $past(!ram_we_n)));

  assert_recovery_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_end_evt |=> (ram_we_n && ram_cs_n && !rsp_done));

  assert_idle_standby_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_cs_n && ram_we_n && ram_oe_n && !ram_dq_oe));

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
  .ADDR_W (ADDR_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_ready      (req_ready),
  .rsp_done       (rsp_done),
  .ram_cs_n       (ram_cs_n),
  .ram_we_n       (ram_we_n),
  .ram_oe_n       (ram_oe_n),
  .ram_addr       (ram_addr),
  .ram_dq_oe      (ram_dq_oe),
  .accept_evt     (accept_evt),
  .capture_evt    (capture_evt),
  .strobe_end_evt (strobe_end_evt)
);

// File: tb/test_sram_strobe_ctrl.sv
module test_sram_strobe_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NS_SETUP = 0, NS_ACC = 45, NS_WP = 35, NS_DS = 20;
  localparam int NS_OFF = 25, NS_WC = 40, NS_WR = 0;

  // own cycle arithmetic: smallest count whose span covers the time
  function automatic int span_cyc(input int ns);
    int c;
    c = 0;
    while (c * CLK_PERIOD < ns) c = c + 1;
    return c;
  endfunction

  int e_setup, e_acc, e_wp, e_off, e_wide, e_rec;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_write, req_keep_oe;
  logic [13:0] req_addr;
  logic [3:0] req_wdata;
  logic       req_ready, rsp_done;
  logic [3:0] rsp_rdata;
  logic       ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe;
  logic [13:0] ram_addr;
  logic [3:0] ram_dq_out;
  logic [3:0] ram_dq_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_strobe_ctrl #(
    .CLK_PERIOD_NS   (CLK_PERIOD),
    .T_ADDR_SETUP_NS (NS_SETUP),
    .T_ACCESS_NS     (NS_ACC),
    .T_WPULSE_NS     (NS_WP),
    .T_DSETUP_NS     (NS_DS),
    .T_BUS_OFF_NS    (NS_OFF),
    .T_WCYCLE_NS     (NS_WC),
    .T_WREC_NS       (NS_WR)
  ) i_sram_strobe_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_keep_oe(req_keep_oe), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
    .ram_addr(ram_addr), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
    .ram_dq_in(ram_dq_in)
  );

  typedef struct {
    bit        cs_n, we_n, oe_n, drv, done, ready;
    bit        chk_addr;
    bit [13:0] addr;
    bit        chk_dq;
    bit [3:0]  dq;
    bit        chk_rd;
    bit [3:0]  rd;
    string     tag;
  } frame_t;

  frame_t     expq[$];
  logic [3:0] ram_cells[int];   // memory model on the bus
  logic [3:0] shadow[int];      // words the bench has written
  int         checks = 0;
  int         failures = 0;
  int         cycles = 0;
  bit         prev_wr_overlap = 1'b0;

  function automatic logic [3:0] cell_of(input logic [13:0] a);
    if (ram_cells.exists(int'(a))) return ram_cells[int'(a)];
    return 4'h0;
  endfunction

  function automatic frame_t quiet(input string tag);
    frame_t f;
    f = '{cs_n:1, we_n:1, oe_n:1, drv:0, done:0, ready:1, chk_addr:0, addr:0,
          chk_dq:0, dq:0, chk_rd:0, rd:0, tag:tag};
    return f;
  endfunction

  function automatic frame_t busy(input bit cs_n, we_n, oe_n, drv, done,
                                  input logic [13:0] a, input string tag);
    frame_t f;
    f = quiet(tag);
    f.cs_n = cs_n; f.we_n = we_n; f.oe_n = oe_n; f.drv = drv; f.done = done;
    f.ready = 0; f.chk_addr = 1; f.addr = a;
    return f;
  endfunction

  task automatic print_summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // memory model: drives the bus during reads, refreshed after each edge
  always @(posedge clk) begin
    #1;
    if (!ram_cs_n && ram_we_n && !ram_oe_n) ram_dq_in = cell_of(ram_addr);
    else if (ram_dq_oe) ram_dq_in = ram_dq_out;
    else ram_dq_in = 4'hz;
  end

  // per-cycle comparison against the expected frame
  always @(negedge clk) begin
    frame_t f;
    bit bad;
    if (expq.size() > 0) f = expq.pop_front();
    else f = quiet(rst_n ? "R11" : "R1");
    bad = 0;
    checks++;
    if (ram_cs_n !== f.cs_n || ram_we_n !== f.we_n || ram_oe_n !== f.oe_n) begin
      bad = 1;
      $display("FAIL %s strobes cs/we/oe=%b%b%b expected %b%b%b", f.tag,
               ram_cs_n, ram_we_n, ram_oe_n, f.cs_n, f.we_n, f.oe_n);
    end
    if (ram_dq_oe !== f.drv || rsp_done !== f.done || req_ready !== f.ready) begin
      bad = 1;
      $display("FAIL %s drv/done/ready=%b%b%b expected %b%b%b", f.tag,
               ram_dq_oe, rsp_done, req_ready, f.drv, f.done, f.ready);
    end
    if (f.chk_addr && ram_addr !== f.addr) begin
      bad = 1;
      $display("FAIL %s ram_addr=%h expected %h", f.tag, ram_addr, f.addr);
    end
    if (f.chk_dq && ram_dq_out !== f.dq) begin
      bad = 1;
      $display("FAIL %s ram_dq_out=%h expected %h", f.tag, ram_dq_out, f.dq);
    end
    if (f.chk_rd && rsp_rdata !== f.rd) begin
      bad = 1;
      $display("FAIL %s rsp_rdata=%h expected %h", f.tag, rsp_rdata, f.rd);
    end
    if (!ram_cs_n && ram_we_n && !ram_oe_n && ram_dq_oe === 1'b1) begin
      bad = 1;
      $display("FAIL R8 bus clash dq_oe=%b expected 0", ram_dq_oe);
    end
    // write commits when the chip-select/write-enable overlap ends
    if (prev_wr_overlap && !(!ram_cs_n && !ram_we_n)) begin
      if (ram_dq_oe !== 1'b1) begin
        bad = 1;
        $display("FAIL R6 data not held at end of write dq_oe=%b expected 1", ram_dq_oe);
      end
      ram_cells[int'(ram_addr)] = ram_dq_out;
    end
    prev_wr_overlap = (!ram_cs_n && !ram_we_n);
    if (bad) failures++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      failures++;
      $display("FAIL watchdog expired after %0d cycles expected completion", cycles);
      print_summary();
      $finish;
    end
  end

  // called one step after a rising edge of an idle cycle
  task automatic issue(input bit wr, input bit keep, input logic [13:0] a,
                       input logic [3:0] d, input bit scramble);
    int wp;
    frame_t f;
    req_valid = 1; req_write = wr; req_keep_oe = keep; req_addr = a; req_wdata = d;
    expq.push_back(quiet("R2"));
    expq.push_back(busy(1, 1, 1, 0, 0, a, "R3"));
    for (int i = 1; i < e_setup; i++) expq.push_back(busy(1, 1, 1, 0, 0, a, "R3"));
    if (!wr) begin
      for (int i = 0; i < e_acc; i++) expq.push_back(busy(0, 1, 0, 0, 0, a, "R4"));
      f = busy(1, 1, 1, 0, 1, a, "R5 R10");
      f.chk_rd = 1;
      f.rd = shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0;
      expq.push_back(f);
    end else begin
      wp = keep ? e_wide : e_wp;
      for (int i = 0; i < wp; i++) begin
        f = busy(0, 0, keep ? 0 : 1, keep ? (i >= e_off) : 1, 0, a, keep ? "R7" : "R6");
        f.chk_dq = f.drv; f.dq = d;
        expq.push_back(f);
      end
      for (int i = 0; i < e_rec; i++) begin
        f = busy(1, 1, 1, i == 0, 0, a, "R8 R9");
        f.chk_dq = f.drv; f.dq = d;
        expq.push_back(f);
      end
      expq.push_back(busy(1, 1, 1, 0, 1, a, "R5 R10"));
      shadow[int'(a)] = d;
    end
    @(posedge clk); #2;
    if (!scramble) req_valid = 0;
    while (expq.size() > 1) begin
      if (scramble) begin
        req_addr = req_addr ^ 14'h2A55; req_wdata = req_wdata + 4'h3;
        req_write = ~req_write; req_keep_oe = ~req_keep_oe;
      end
      @(posedge clk); #2;
    end
    req_valid = 0;
    while (expq.size() > 0) begin
      @(posedge clk); #2;
    end
  endtask

  initial begin
    e_setup = span_cyc(NS_SETUP); if (e_setup < 1) e_setup = 1;
    e_acc   = span_cyc(NS_ACC);
    e_wp    = span_cyc(NS_WP);
    e_off   = span_cyc(NS_OFF);
    e_wide  = e_off + span_cyc(NS_DS);
    if (e_wide < e_wp) e_wide = e_wp;
    e_rec   = span_cyc(NS_WC) - e_setup - e_wp;
    if (span_cyc(NS_WR) > e_rec) e_rec = span_cyc(NS_WR);
    if (e_rec < 1) e_rec = 1;
    // R10: fixed expectations for the chosen figures
    checks++;
    if (e_setup != 1 || e_acc != 5 || e_wp != 4 || e_wide != 5 || e_off != 3 || e_rec != 1) begin
      failures++;
      $display("FAIL R10 derived counts %0d %0d %0d %0d %0d %0d expected 1 5 4 5 3 1",
               e_setup, e_acc, e_wp, e_wide, e_off, e_rec);
    end

    rst_n = 0; req_valid = 0; req_write = 0; req_keep_oe = 0;
    req_addr = '0; req_wdata = '0; ram_dq_in = 4'hz;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(posedge clk); #2;

    issue(1, 0, 14'h0005, 4'hA, 0);   // R6 plain write
    issue(0, 0, 14'h0005, 4'h0, 0);   // R4 read back
    issue(1, 1, 14'h3FFF, 4'h3, 0);   // R7 widened write, top address
    issue(0, 0, 14'h3FFF, 4'h0, 0);
    issue(1, 0, 14'h0000, 4'hF, 0);   // bottom address
    issue(0, 1, 14'h0000, 4'h0, 0);   // keep flag has no effect on reads
    issue(0, 0, 14'h1234, 4'h0, 0);   // never written
    issue(1, 1, 14'h2222, 4'h6, 1);   // R2 inputs churn while busy
    issue(0, 0, 14'h2222, 4'h0, 1);   // R2 churn during read
    issue(0, 0, 14'h0005, 4'h0, 0);   // earlier write survives
    repeat (4) @(posedge clk);
    #2;
    print_summary();
    $finish;
  end

endmodule